// File: doc/BRIEF.md
# Scrambling Line Encoder with Carry Prefix

The block turns 16-bit message words into 18-bit line symbols for a serial differential link. A pair of 16-bit registers with an end-around carry forms a generator that advances once per accepted word. The payload is the word XORed with the generator's X register. The message word, minus a correction bit D, is folded into the next generator state, so a matching decoder can recover the data.

A 2-bit prefix sits in front of every payload. It is the output of a half-adder on the generator carry C and the correction bit D. A half-adder can never produce the value 11, so that prefix is reserved. A packet-start request sends prefix 11 with a fixed start pattern and leaves the generator untouched. An init pulse reloads the generator seed. Each symbol appears on the output register one cycle after its request.

Top module: `lc_scrambler_enc`

## Requirements
- R1: After reset, `sym_vld_o` is 0 and `sym_o` is 0. The generator holds X=0x6DDB, Y=0xDD6D, C=0, D=0.
- R2: When `init_i` is high, the generator reloads the R1 values and no symbol is emitted in the next cycle. `init_i` overrides `sop_i` and `word_vld_i`.
- R3: A word accepted in cycle n appears in cycle n+1 with `sym_vld_o`=1 and `sym_o[15:0]` = word XOR X, where X is the value before the update.
- R4: For a data symbol, `sym_o[17]` = C AND D and `sym_o[16]` = C XOR D. C and D are the values before the update.
- R5: Each accepted word updates the generator as follows:
  - sum = X+Y+C, 17 bits wide;
  - C takes sum[16];
  - Y takes the old X;
  - X takes (sum[15:0] + word − D) mod 2^16;
  - D takes the old X[15].
- R6: A data symbol never carries prefix `sym_o[17:16]`=11.
- R7: When `sop_i` is high and `init_i` is low, the next cycle shows `sym_vld_o`=1 and `sym_o` = {2'b11, START}, with START defaulting to 0x0000. The generator does not advance, and a word offered in the same cycle is dropped.
- R8: With no request, `sym_vld_o` is 0 in the next cycle and the generator holds its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Reload the generator seed |
| sop_i | input | 1 | Request a packet-start symbol |
| word_vld_i | input | 1 | Message word valid |
| word_i | input | 16 | Message word |
| sym_o | output | 18 | Line symbol {prefix, payload} |
| sym_vld_o | output | 1 | Symbol valid |

## Verification
A packet-start request and a valid word can arrive in the same cycle. So can an init pulse and a valid word. The bench raises these pairs on a regular cadence while it sweeps walking, edge and pseudo-random words.

For each collision, the bench checks three things:
- the emitted symbol is the start symbol, or no symbol at all;
- the next ordinary word matches an arithmetic model that left the generator unadvanced (for a start collision) or reseeded (for an init collision);
- the dropped word had no effect on that next symbol.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic [1:0] {OP_IDLE, OP_INIT, OP_SOP, OP_WORD} lc_op_e;
endpackage

// File: rtl/lc_op_dec.sv
module lc_op_dec
  import lc_pkg::*;
(
  input  logic   init_i,
  input  logic   sop_i,
  input  logic   word_vld_i,
  output lc_op_e op_o
);
  always_comb begin
    if (init_i)          op_o = OP_INIT;
    else if (sop_i)      op_o = OP_SOP;
    else if (word_vld_i) op_o = OP_WORD;
    else                 op_o = OP_IDLE;
  end
endmodule

// File: rtl/lc_gen.sv
module lc_gen
  import lc_pkg::*;
#(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] INIT_X = 16'h6DDB,
  parameter logic [W-1:0] INIT_Y = 16'hDD6D
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  lc_op_e       op_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o,
  output logic         c_o,
  output logic         d_o
);
  logic [W-1:0] x_q, y_q, enc, x_n;
  logic [W:0]   sum;
  logic         c_q, d_q;

  always_comb begin
    sum = {1'b0, x_q} + {1'b0, y_q} + {{W{1'b0}}, c_q};
    enc = word_i - {{(W-1){1'b0}}, d_q};  // subtract D: keeps decode exact
    x_n = sum[W-1:0] + enc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= INIT_X;
      y_q <= INIT_Y;
      c_q <= 1'b0;
      d_q <= 1'b0;
    end else begin
      case (op_i)
        OP_INIT: begin
          x_q <= INIT_X;
          y_q <= INIT_Y;
          c_q <= 1'b0;
          d_q <= 1'b0;
        end
        OP_WORD: begin
          x_q <= x_n;
          y_q <= x_q;
          c_q <= sum[W];
          d_q <= x_q[W-1];
        end
        default: ;
      endcase
    end
  end

  assign x_o = x_q;
  assign y_o = y_q;
  assign c_o = c_q;
  assign d_o = d_q;
endmodule

// File: rtl/lc_prefix.sv
module lc_prefix (
  input  logic       c_i,
  input  logic       d_i,
  output logic [1:0] pfx_o
);
  // half-adder: {carry, sum}; 2'b11 cannot occur
  assign pfx_o = {c_i & d_i, c_i ^ d_i};
endmodule

// File: rtl/lc_scrambler_enc.sv
module lc_scrambler_enc
  import lc_pkg::*;
#(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] INIT_X = 16'h6DDB,
  parameter logic [W-1:0] INIT_Y = 16'hDD6D,
  parameter logic [W-1:0] START  = 16'h0000,
  localparam int unsigned SW = W + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          sop_i,
  input  logic          word_vld_i,
  input  logic [W-1:0]  word_i,
  output logic [SW-1:0] sym_o,
  output logic          sym_vld_o
);
  lc_op_e       op;
  logic [W-1:0] gx, gy;
  logic         gc, gd;
  logic [1:0]   pfx;
  logic [SW-1:0] sym_q;
  logic          vld_q;

  lc_op_dec u_dec (
    .init_i(init_i), .sop_i(sop_i), .word_vld_i(word_vld_i), .op_o(op)
  );

  lc_gen #(.W(W), .INIT_X(INIT_X), .INIT_Y(INIT_Y)) u_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op), .word_i(word_i),
    .x_o(gx), .y_o(gy), .c_o(gc), .d_o(gd)
  );

  lc_prefix u_pfx (.c_i(gc), .d_i(gd), .pfx_o(pfx));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_q <= '0;
      vld_q <= 1'b0;
    end else begin
      case (op)
        OP_WORD: begin
          sym_q <= {pfx, word_i ^ gx};
          vld_q <= 1'b1;
        end
        OP_SOP: begin
          sym_q <= {2'b11, START};
          vld_q <= 1'b1;
        end
        default: vld_q <= 1'b0;
      endcase
    end
  end

  assign sym_o     = sym_q;
  assign sym_vld_o = vld_q;
endmodule

// File: rtl/lc_enc_chk.sv
module lc_enc_chk #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] INIT_X = 16'h6DDB,
  parameter logic [W-1:0] INIT_Y = 16'hDD6D,
  parameter logic [W-1:0] START  = 16'h0000
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           init_i,
  input logic           sop_i,
  input logic           word_vld_i,
  input logic [W+1:0]   sym_o,
  input logic           sym_vld_o,
  input logic [W-1:0]   gx,
  input logic [W-1:0]   gy,
  input logic           gc,
  input logic           gd
);
  AST_INIT_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (gx == INIT_X && gy == INIT_Y && !gc && !gd && !sym_vld_o)); // R2
  AST_WORD_PREFIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_i && !sop_i && !init_i) |=> (sym_vld_o && sym_o[W+1:W] != 2'b11)); // R6
  AST_WORD_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_i && !sop_i && !init_i) |=> (gy == $past(gx) && gd == $past(gx[W-1]))); // R5
  AST_SOP_SYMBOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sop_i && !init_i) |=> (sym_vld_o && sym_o == {2'b11, START})); // R7
  AST_SOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sop_i && !init_i) |=> ($stable(gx) && $stable(gy) && $stable(gc) && $stable(gd))); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !sop_i && !word_vld_i) |=> (!sym_vld_o && $stable(gx) && $stable(gy))); // R8
endmodule

bind lc_scrambler_enc lc_enc_chk #(
  .W(W), .INIT_X(INIT_X), .INIT_Y(INIT_Y), .START(START)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_i), .sop_i(sop_i),
  .word_vld_i(word_vld_i), .sym_o(sym_o), .sym_vld_o(sym_vld_o),
  .gx(gx), .gy(gy), .gc(gc), .gd(gd)
);

// File: tb/sim_lc_scrambler_enc.sv
module sim_lc_scrambler_enc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        init_i = 1'b0, sop_i = 1'b0, word_vld_i = 1'b0;
  logic [15:0] word_i = '0;
  logic [17:0] sym_o;
  logic        sym_vld_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] mx, my;
  logic        mc, md;

  always #4 clk_i = ~clk_i;  // 125 MHz

  lc_scrambler_enc u0 (.*);

  task automatic seed();
    mx = 16'h6DDB; my = 16'hDD6D; mc = 1'b0; md = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle of requests, then check the registered result
  task automatic step(input bit ini, input bit sop, input bit vld, input logic [15:0] w);
    logic [17:0] es;
    logic        ev;
    logic [16:0] sum;
    ev = 1'b0; es = '0;
    if (ini) seed();
    else if (sop) begin ev = 1'b1; es = {2'b11, 16'h0000}; end
    else if (vld) begin
      ev = 1'b1;
      es = {mc & md, mc ^ md, w ^ mx};
      sum = {1'b0, mx} + {1'b0, my} + {16'd0, mc};
      my = mx;
      mx = sum[15:0] + (w - {15'd0, md});
      md = es[15] ^ w[15];  // old X[15]
      mc = sum[16];
    end
    init_i = ini; sop_i = sop; word_vld_i = vld; word_i = w;
    @(negedge clk_i);
    chk(ini ? "R2 no symbol after init" : (sop ? "R7 start valid" : (vld ? "R3 valid" : "R8 idle")),
        {31'd0, sym_vld_o}, {31'd0, ev});
    if (ev && sop && !ini) chk("R7 start symbol", {14'd0, sym_o}, {14'd0, es});
    if (ev && !sop) begin
      chk("R3 payload", {16'd0, sym_o[15:0]}, {16'd0, es[15:0]});
      chk("R4 prefix", {30'd0, sym_o[17:16]}, {30'd0, es[17:16]});
      if (sym_o[17:16] == 2'b11) chk("R6 reserved prefix", 32'd3, 32'd0);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    seed();
    repeat (3) @(negedge clk_i);
    chk("R1 reset valid", {31'd0, sym_vld_o}, 32'd0);
    chk("R1 reset symbol", {14'd0, sym_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 seed seen through the first words; R5 via chaining
    step(0, 0, 1, 16'h0000);
    step(0, 0, 1, 16'hFFFF);
    step(0, 0, 0, 16'h1234);  // R8 idle holds state
    for (int i = 0; i < 16; i++) step(0, 0, 1, 16'h1 << i);
    for (int i = 0; i < 16; i++) step(0, 0, 1, ~(16'h1 << i));
    step(1, 0, 1, 16'hABCD);  // R2 init beats word
    step(0, 0, 1, 16'h0000);
    lf = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (i % 53 == 7)        step(0, 1, 1, lf);  // R7 collision, word dropped
      else if (i % 37 == 3)   step(0, 1, 0, lf);  // R7 start
      else if (i % 997 == 500) step(1, 1, 1, lf); // R2 beats all
      else if (i % 29 == 11)  step(0, 0, 0, lf);  // R8
      else if (i % 5 == 0)    step(0, 0, 1, 16'hFFFF);
      else                    step(0, 0, 1, lf);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule